// File: doc/BRIEF.md
# Bus-Attached I/O Port with Partial Address Decode

This block is the peripheral side of one I/O port on a simple 16-bit processor bus. It watches the address lines and the I/O read and write strobes and decides whether it is the port being addressed. The match is a product of address lines: each line whose expected value is zero is inverted first, and then all the compared lines are ANDed together. A parameter can leave some of the upper address lines out of the match. The port then answers at every address that agrees on the lines that remain, so its small window of addresses repeats across the whole address space.

When the port is selected and the read strobe is active, it puts the peripheral's input data on the read-data bus and raises an output enable. At all other times it drives zero and keeps the enable low, so other ports on the bus are never disturbed. When the port is selected and the write strobe is active, it captures the bus data into an output register on the next rising clock edge.

The port is built in one of two modes. In word mode it is one 16-bit port at an even address. In byte mode it is two 8-bit ports at two neighbouring addresses. Each byte port is wired to its own half of the data bus, and only that half is used in a given access. A synchronous reset clears the output register.

Top module: `io_port_dec`

## Requirements
- R1: The port is selected when address bits `[15-IGNORE_HI : L]` equal the same bits of `BASE`, where L is 0 in word mode and 1 in byte mode. The top `IGNORE_HI` address bits have no effect, so with `IGNORE_HI = 8` addresses 0x0040, 0xA540 and 0xFF40 all reach a port whose `BASE` is 0x0040.
- R2: In word mode, bit 0 of the address is part of the match and `BASE` bit 0 must be 0. An odd address therefore never selects the port: it does not write and it does not drive the read bus.
- R3: In byte mode, an address with bit 0 = 0 reaches the low byte lane (data bits 7:0), and the same address with bit 0 = 1 reaches the high byte lane (data bits 15:8).
- R4: `bus_rdata_oe` is 1 exactly while the port is selected and `bus_rd` is 1, in the same cycle as the access. While `bus_rdata_oe` is 0, `bus_rdata` is all zeros.
- R5: `dev_out` takes the write data at the rising clock edge that ends a cycle in which the port is selected and `bus_wr` is 1. In every other cycle `dev_out` keeps its value.
- R6: A byte-mode write changes only the addressed byte of `dev_out`, and that byte takes its value from the matching half of `bus_wdata`. The other byte keeps its value.
- R7: A rising clock edge with `rst` = 1 sets `dev_out` to 0x0000.
- R8: With `IGNORE_HI = 0` every address line is decoded. An address that differs from `BASE` only in bit 15 does not select the port.
- R9: A read returns data as follows. In word mode the full `dev_in` appears on `bus_rdata`. In byte mode the addressed lane of `dev_in` appears on the same lane of `bus_rdata`, and the other lane reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Processor address bus |
| bus_rd | input | 1 | I/O read strobe, active high |
| bus_wr | input | 1 | I/O write strobe, active high |
| bus_wdata | input | 16 | Write data from the processor |
| bus_rdata | output | 16 | Read data to the processor; zero when the port is not driving |
| bus_rdata_oe | output | 1 | High while the port drives the read bus |
| dev_in | input | 16 | Input value from the peripheral |
| dev_out | output | 16 | Output register to the peripheral |

## Verification
The read path has no registers, so `bus_rdata` and `bus_rdata_oe` are due in the same cycle as the address and read strobe. The bench drives its inputs on the falling edge and compares these outputs a short delay later. `dev_out` changes one rising edge after the write cycle, so the bench compares it just after that edge. The bench compares it again on every later access to confirm that misses, odd addresses and lanes that were not written leave it unchanged. Reset is checked in the same way, one edge after `rst` is applied.

// File: rtl/io_port_pkg.sv
package io_port_pkg;

   localparam int LANE_W = 8;

   typedef enum logic [0:0] {
      PORT_WORD = 1'b0,
      PORT_BYTE = 1'b1
   } port_mode_e;

   // Lowest address bit that takes part in the match for a given mode.
   function automatic int first_decoded_bit(port_mode_e mode);
      return (mode == PORT_BYTE) ? 1 : 0;
   endfunction

endpackage

// File: rtl/io_addr_match.sv
// Product-term address match: every decoded line is inverted when the base
// expects 0 there, then all decoded lines are ANDed.
module io_addr_match #(
   parameter int              FIELD_W = 8,
   parameter logic [FIELD_W-1:0] FIELD_BASE = '0
) (
   input  logic [FIELD_W-1:0] addr_field,
   output logic               hit
);

   logic [FIELD_W-1:0] term;

   for (genvar i = 0; i < FIELD_W; i++) begin : g_term
      if (FIELD_BASE[i]) begin : g_one
         assign term[i] = addr_field[i];
      end else begin : g_zero
         assign term[i] = ~addr_field[i];
      end
   end

   assign hit = &term;

endmodule

// File: rtl/io_out_latch.sv
// Per-lane output register with synchronous reset.
module io_out_latch #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    wr_fire,
   input  logic [LANES-1:0]        lane_en,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] q
);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst) begin
            q[k*LANE_W +: LANE_W] <= '0;
         end else if (wr_fire && lane_en[k]) begin
            q[k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
         end
      end
   end

endmodule

// File: rtl/io_rd_mux.sv
// Read return: each lane is gated by the select and its lane enable,
// so a port that is not addressed drives all zeros.
module io_rd_mux #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                    rd_fire,
   input  logic [LANES-1:0]        lane_en,
   input  logic [LANES*LANE_W-1:0] dev_in,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_oe
);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      always_comb begin
         if (rd_fire && lane_en[k]) begin
            rdata[k*LANE_W +: LANE_W] = dev_in[k*LANE_W +: LANE_W];
         end else begin
            rdata[k*LANE_W +: LANE_W] = '0;
         end
      end
   end

   assign rdata_oe = rd_fire;

endmodule

// File: rtl/io_port_dec.sv
module io_port_dec #(
   parameter int                      ADDR_W    = 16,
   parameter int                      DATA_W    = 16,
   parameter int                      IGNORE_HI = 8,
   parameter io_port_pkg::port_mode_e MODE      = io_port_pkg::PORT_WORD,
   parameter logic [ADDR_W-1:0]       BASE      = 16'h0040
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rdata_oe,
   input  logic [DATA_W-1:0] dev_in,
   output logic [DATA_W-1:0] dev_out
);

   localparam int LANE_W  = io_port_pkg::LANE_W;
   localparam int LANES   = DATA_W / LANE_W;
   localparam int LOW_BIT = io_port_pkg::first_decoded_bit(MODE);
   localparam int TOP_BIT = ADDR_W - 1 - IGNORE_HI;
   localparam int FIELD_W = TOP_BIT - LOW_BIT + 1;

   // Elaboration-time parameter checks
   if (IGNORE_HI < 0 || IGNORE_HI > 8) begin : g_bad_ignore
      $error("io_port_dec: IGNORE_HI must lie in 0..8");
   end
   if (DATA_W % LANE_W != 0) begin : g_bad_width
      $error("io_port_dec: DATA_W must be a whole number of bytes");
   end
   if (MODE == io_port_pkg::PORT_BYTE && LANES != 2) begin : g_bad_byte
      $error("io_port_dec: byte mode needs a two-lane data bus");
   end
   if (BASE[0] != 1'b0) begin : g_bad_align
      $error("io_port_dec: BASE must be even");
   end

   logic             hit;
   logic [LANES-1:0] lane_en;
   logic             rd_fire;
   logic             wr_fire;

   io_addr_match #(
      .FIELD_W   (FIELD_W),
      .FIELD_BASE(BASE[TOP_BIT:LOW_BIT])
   ) u_match (
      .addr_field(bus_addr[TOP_BIT:LOW_BIT]),
      .hit       (hit)
   );

   if (MODE == io_port_pkg::PORT_BYTE) begin : g_byte_lanes
      assign lane_en = bus_addr[0] ? 2'b10 : 2'b01;
   end else begin : g_word_lanes
      assign lane_en = '1;
   end

   assign rd_fire = hit & bus_rd;
   assign wr_fire = hit & bus_wr;

   io_out_latch #(
      .LANES (LANES),
      .LANE_W(LANE_W)
   ) u_latch (
      .clk    (clk),
      .rst    (rst),
      .wr_fire(wr_fire),
      .lane_en(lane_en),
      .wdata  (bus_wdata),
      .q      (dev_out)
   );

   io_rd_mux #(
      .LANES (LANES),
      .LANE_W(LANE_W)
   ) u_rd (
      .rd_fire (rd_fire),
      .lane_en (lane_en),
      .dev_in  (dev_in),
      .rdata   (bus_rdata),
      .rdata_oe(bus_rdata_oe)
   );

endmodule

// File: rtl/io_port_dec_chk.sv
module io_port_dec_chk #(
   parameter int                      ADDR_W    = 16,
   parameter int                      DATA_W    = 16,
   parameter int                      IGNORE_HI = 8,
   parameter io_port_pkg::port_mode_e MODE      = io_port_pkg::PORT_WORD,
   parameter logic [ADDR_W-1:0]       BASE      = 16'h0040
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_rdata_oe,
   input logic [DATA_W-1:0] dev_out
);

   localparam logic IS_BYTE = (MODE == io_port_pkg::PORT_BYTE);
   localparam logic [ADDR_W-1:0] KEEP_MASK =
      ({ADDR_W{1'b1}} >> IGNORE_HI) & ~{{(ADDR_W-1){1'b0}}, IS_BYTE};
   localparam int HALF = DATA_W / 2;

   // R1 / R8: an address that disagrees on a kept line never drives the bus
   a_r1_miss_quiet: assert property (@(posedge clk) disable iff (rst)
      (((bus_addr ^ BASE) & KEEP_MASK) != '0) |-> (!bus_rdata_oe && bus_rdata == '0));

   // R4: the enable needs the read strobe
   a_r4_oe_needs_rd: assert property (@(posedge clk) disable iff (rst)
      bus_rdata_oe |-> bus_rd);

   // R4: a bus that is not driven reads as zero
   a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
      !bus_rdata_oe |-> (bus_rdata == '0));

   // R5: no write strobe, no change
   a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      !bus_wr |=> $stable(dev_out));

   // R7: reset clears the output register
   a_r7_reset_clears: assert property (@(posedge clk)
      rst |=> (dev_out == '0));

   if (IS_BYTE) begin : g_byte_chk
      // R6: a write to the high lane keeps the low byte, and the reverse
      a_r6_low_kept: assert property (@(posedge clk) disable iff (rst)
         (bus_wr && bus_addr[0]) |=> (dev_out[HALF-1:0] == $past(dev_out[HALF-1:0])));
      a_r6_high_kept: assert property (@(posedge clk) disable iff (rst)
         (bus_wr && !bus_addr[0]) |=> (dev_out[DATA_W-1:HALF] == $past(dev_out[DATA_W-1:HALF])));
   end else begin : g_word_chk
      // R2: odd addresses are never served in word mode
      a_r2_odd_quiet: assert property (@(posedge clk) disable iff (rst)
         bus_addr[0] |-> !bus_rdata_oe);
      a_r2_odd_no_write: assert property (@(posedge clk) disable iff (rst)
         bus_addr[0] |=> $stable(dev_out));
   end

endmodule

bind io_port_dec io_port_dec_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .IGNORE_HI(IGNORE_HI),
   .MODE     (MODE),
   .BASE     (BASE)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .bus_addr    (bus_addr),
   .bus_rd      (bus_rd),
   .bus_wr      (bus_wr),
   .bus_rdata   (bus_rdata),
   .bus_rdata_oe(bus_rdata_oe),
   .dev_out     (dev_out)
);

// File: tb/test_io_port_dec.sv
module test_io_port_dec;

   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] BASE_W = 16'h0040;
   localparam logic [15:0] BASE_B = 16'h1234;

   logic clk = 1'b0;
   logic rst = 1'b1;

   logic [15:0] a_w = '0, wd_w = '0, di_w = '0;
   logic        rd_w = 1'b0, wr_w = 1'b0;
   logic [15:0] rdata_w, out_w;
   logic        oe_w;

   logic [15:0] a_b = '0, wd_b = '0, di_b = '0;
   logic        rd_b = 1'b0, wr_b = 1'b0;
   logic [15:0] rdata_b, out_b;
   logic        oe_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [15:0] model_w = '0;
   logic [15:0] model_b = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // Word mode, upper eight lines ignored
   io_port_dec #(
      .ADDR_W(16), .DATA_W(16), .IGNORE_HI(8),
      .MODE(io_port_pkg::PORT_WORD), .BASE(BASE_W)
   ) i_io_port_dec (
      .clk(clk), .rst(rst), .bus_addr(a_w), .bus_rd(rd_w), .bus_wr(wr_w),
      .bus_wdata(wd_w), .bus_rdata(rdata_w), .bus_rdata_oe(oe_w),
      .dev_in(di_w), .dev_out(out_w)
   );

   // Byte mode, full decode
   io_port_dec #(
      .ADDR_W(16), .DATA_W(16), .IGNORE_HI(0),
      .MODE(io_port_pkg::PORT_BYTE), .BASE(BASE_B)
   ) i_io_port_dec_b (
      .clk(clk), .rst(rst), .bus_addr(a_b), .bus_rd(rd_b), .bus_wr(wr_b),
      .bus_wdata(wd_b), .bus_rdata(rdata_b), .bus_rdata_oe(oe_b),
      .dev_in(di_b), .dev_out(out_b)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Behavioural reference: returns the byte mask the access reaches, zero on a miss
   function automatic logic [15:0] reach(input bit sel_b, input logic [15:0] a);
      if (sel_b) begin
         if (((a ^ BASE_B) & 16'hFFFE) != 16'h0000) return 16'h0000;
         return a[0] ? 16'hFF00 : 16'h00FF;
      end
      if (((a ^ BASE_W) & 16'h00FF) != 16'h0000) return 16'h0000;
      return 16'hFFFF;
   endfunction

   task automatic access(input bit sel_b, input logic [15:0] a, input bit rd, input bit wr,
                         input logic [15:0] wd, input logic [15:0] din, input string req);
      logic [15:0] m;
      logic [15:0] exp_rd;
      @(negedge clk);
      if (sel_b) begin
         a_b = a; rd_b = rd; wr_b = wr; wd_b = wd; di_b = din;
         rd_w = 1'b0; wr_w = 1'b0;
      end else begin
         a_w = a; rd_w = rd; wr_w = wr; wd_w = wd; di_w = din;
         rd_b = 1'b0; wr_b = 1'b0;
      end
      m = reach(sel_b, a);
      exp_rd = rd ? (din & m) : 16'h0000;
      #1;
      if (sel_b) begin
         check({req, " rdata"}, rdata_b, exp_rd);
         check({req, " oe"}, {15'b0, oe_b}, {15'b0, (rd && m != 0)});
         check({req, " other port idle"}, {15'b0, oe_w}, 16'h0000);
      end else begin
         check({req, " rdata"}, rdata_w, exp_rd);
         check({req, " oe"}, {15'b0, oe_w}, {15'b0, (rd && m != 0)});
         check({req, " other port idle"}, {15'b0, oe_b}, 16'h0000);
      end
      @(posedge clk);
      if (wr) begin
         if (sel_b) model_b = (model_b & ~m) | (wd & m);
         else       model_w = (model_w & ~m) | (wd & m);
      end
      #1;
      check({req, " dev_out word"}, out_w, model_w);
      check({req, " dev_out byte"}, out_b, model_b);
      @(negedge clk);
      rd_w = 1'b0; wr_w = 1'b0; rd_b = 1'b0; wr_b = 1'b0;
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      model_w = '0;
      model_b = '0;
      #1;
      check("R7 reset word", out_w, 16'h0000);
      check("R7 reset byte", out_b, 16'h0000);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      repeat (2) @(posedge clk);
      apply_reset();
      #1;
      check("R4 idle rdata after reset", rdata_w | rdata_b, 16'h0000);

      // Word mode
      access(0, 16'h0040, 0, 1, 16'hBEEF, 16'h0000, "R5 word write");
      access(0, 16'h0040, 1, 0, 16'h0000, 16'h1357, "R4 R9 word read");
      access(0, 16'hA540, 0, 1, 16'h1111, 16'h0000, "R1 alias write");
      access(0, 16'hFF40, 1, 0, 16'h0000, 16'h2468, "R1 alias read");
      access(0, 16'h0041, 0, 1, 16'h9999, 16'h0000, "R2 odd write");
      access(0, 16'h0041, 1, 0, 16'h0000, 16'h7777, "R2 odd read");
      access(0, 16'h0042, 1, 1, 16'h5555, 16'h3333, "R5 miss");
      access(0, 16'h0040, 0, 0, 16'hAAAA, 16'h4444, "R4 no strobe");
      access(0, 16'h0040, 1, 1, 16'hC0DE, 16'h6161, "R4 R5 read and write");

      // Byte mode
      access(1, 16'h1234, 0, 1, 16'hAB5C, 16'h0000, "R3 R6 low lane write");
      access(1, 16'h1235, 0, 1, 16'h7E00, 16'h0000, "R3 R6 high lane write");
      access(1, 16'h1235, 0, 1, 16'h00C3, 16'h0000, "R6 high lane uses upper half");
      access(1, 16'h1234, 1, 0, 16'h0000, 16'hA1B2, "R9 low lane read");
      access(1, 16'h1235, 1, 0, 16'h0000, 16'hA1B2, "R9 high lane read");
      access(1, 16'h9234, 1, 1, 16'hFFFF, 16'hFFFF, "R8 full decode miss");
      access(1, 16'h1236, 1, 1, 16'hFFFF, 16'hFFFF, "R8 neighbour miss");
      access(1, 16'h1235, 0, 1, 16'h9A00, 16'h0000, "R6 high lane again");

      apply_reset();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule